// File: doc/BRIEF.md
# QPSK Pulse-Shaping Modulator

This block turns a stream of two-bit QPSK symbols into one modulated sample stream at four times the symbol rate. Each symbol bit becomes an antipodal level (+1 or -1) on either the in-phase or the quadrature branch. Each branch holds a short history of those levels and runs a four-phase interpolating root-raised-cosine filter. Because the filter input is only ever +1 or -1, every tap either adds its stored coefficient or subtracts it, so the filter has no multipliers.

The two filtered branches are multiplied by cosine and sine carrier samples. An external oscillator supplies these samples on input ports. The block forms in-phase times cosine minus quadrature times sine and keeps the result at full precision. A source offers symbols with a valid/ready handshake. The block takes one symbol in every fourth clock and emits one output sample on every clock.

Top module: `qpsk_rrc_mod`

## Requirements
- R1: While `rst_n` is low at a rising edge, `mod_out` is cleared to 0 at that edge. The phase counter returns to phase 0 and every stored symbol level in both branches returns to +1.
- R2: `sym_ready` is high exactly when the phase counter is at phase 3. The counter steps 0,1,2,3,0 on every clock, so `sym_ready` is high one cycle in four, and it first rises in the fourth cycle after reset is released.
- R3: At a rising edge where `sym_ready` and `sym_valid` are both high, `sym_bits[1]` enters the in-phase history and `sym_bits[0]` enters the quadrature history. A bit value of 0 means +1 and a value of 1 means -1.
- R4: At a rising edge where `sym_ready` is high and `sym_valid` is low, a +1 level enters both histories.
- R5: With phase p before an edge and stored levels s[0] (newest) through s[9], each branch value is the sum over m = 0..9 of s[m]·h[4m+p]. The table h has 40 taps, quantised to 10-bit signed values scaled by 512. It is symmetric about tap 18, which holds 229, and taps 37, 38 and 39 are zero.
- R6: Each branch value is a 14-bit signed number. It never exceeds in magnitude the sum of the absolute values of all coefficients, so no operand pattern overflows it.
- R7: At each rising edge outside reset, `mod_out` takes I·cos − Q·sin as a 25-bit signed value. I and Q are the branch values defined by R5 before that edge, and cos and sin are the signed values on `car_cos` and `car_sin` just before that edge.
- R8: `sym_valid` and `sym_bits` have no effect at edges where `sym_ready` is low.
- R9: When both histories are all -1 and the carriers are at -512 and +511, the output is still the exact product difference, with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one output per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | Source offers a symbol |
| sym_bits | input | 2 | Symbol: bit 1 in-phase, bit 0 quadrature, 0 = +1, 1 = -1 |
| sym_ready | output | 1 | Block takes a symbol at this edge (phase 3) |
| car_cos | input | 10 | Signed cosine carrier sample |
| car_sin | input | 10 | Signed sine carrier sample |
| mod_out | output | 25 | Signed modulated sample, I·cos − Q·sin |

## Verification
Symbol acceptance and a fresh filter output fall in the same clock. At the phase-3 edge the newest history slot is overwritten, and in that same cycle `mod_out` is registered from the old history at the last phase. One cycle later the new symbol is already weighted by the phase-0 coefficients. The bench provokes this collision by changing the symbol and both carriers at every phase-3 edge, including runs where the offered bits also change while `sym_ready` is low. It judges each output sample against a model that computes the result from the history before the edge.

// File: rtl/qpsk_mod_pkg.sv
// Package: shared sizes and the pulse-shaping coefficient table.
// Assumes: taps beyond the 37-tap prototype are zero padding.
package qpsk_mod_pkg;

    localparam int PHASES         = 4;
    localparam int TAPS_PER_PHASE = 10;
    localparam int TOTAL_TAPS     = PHASES * TAPS_PER_PHASE;
    localparam int PROTO_TAPS     = 37;
    localparam int CENTRE_TAP     = (PROTO_TAPS - 1) / 2;
    localparam int COEF_W         = 10;

    // Quantised half response (taps 0..centre), scale 2^9.
    function automatic logic signed [COEF_W-1:0] half_coef(input int k);
        case (k)
            0:  half_coef = -10'sd5;
            1:  half_coef = -10'sd5;
            2:  half_coef = -10'sd1;
            3:  half_coef = 10'sd5;
            4:  half_coef = 10'sd12;
            5:  half_coef = 10'sd15;
            6:  half_coef = 10'sd12;
            7:  half_coef = 10'sd2;
            8:  half_coef = -10'sd12;
            9:  half_coef = -10'sd28;
            10: half_coef = -10'sd39;
            11: half_coef = -10'sd37;
            12: half_coef = -10'sd18;
            13: half_coef = 10'sd19;
            14: half_coef = 10'sd70;
            15: half_coef = 10'sd127;
            16: half_coef = 10'sd179;
            17: half_coef = 10'sd216;
            18: half_coef = 10'sd229;
            default: half_coef = '0;
        endcase
    endfunction

    // Full padded table, mirrored about the centre tap.
    function automatic logic signed [COEF_W-1:0] coef_at(input int idx);
        if (idx < 0 || idx >= PROTO_TAPS)
            coef_at = '0;
        else if (idx <= CENTRE_TAP)
            coef_at = half_coef(idx);
        else
            coef_at = half_coef(PROTO_TAPS - 1 - idx);
    endfunction

    // Sum of coefficient magnitudes, a hard bound on any branch value.
    function automatic int coef_abs_sum();
        int acc;
        acc = 0;
        for (int i = 0; i < TOTAL_TAPS; i++) begin
            int v;
            v = int'(coef_at(i));
            acc += (v < 0) ? -v : v;
        end
        return acc;
    endfunction

endpackage

// File: rtl/qpsk_phase_ctrl.sv
// Module: interpolation phase counter and symbol-intake strobe.
// Assumes: the counter free-runs and one symbol slot opens per full cycle.
module qpsk_phase_ctrl
    import qpsk_mod_pkg::*;
#(
    parameter int NUM_PHASES = PHASES,
    localparam int PH_W      = $clog2(NUM_PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            last_phase
);

    localparam logic [PH_W-1:0] LAST = PH_W'(NUM_PHASES - 1);

    // Advance the phase, wrapping after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (phase == LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    // Intake strobe for the final phase.
    always_comb last_phase = (phase == LAST);

    // R2
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_phase |=> !last_phase);

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_phase |=> (phase == '0));

endmodule

// File: rtl/qpsk_shaper_branch.sv
// Module: one branch of the pulse shaper, a symbol history plus a polyphase
// add/subtract sum. Assumes: a stored 1 means level -1, and 0 means +1.
module qpsk_shaper_branch
    import qpsk_mod_pkg::*;
#(
    parameter int NUM_PHASES = PHASES,
    parameter int DEPTH      = TAPS_PER_PHASE,
    parameter int ACC_W      = 14,
    localparam int PH_W      = $clog2(NUM_PHASES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift,
    input  logic                    new_bit,
    input  logic [PH_W-1:0]         phase,
    output logic signed [ACC_W-1:0] acc
);

    localparam int BOUND = coef_abs_sum();

    logic [DEPTH-1:0] line;

    // Symbol history: newest level in slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line <= '0;
        else if (shift)
            line <= {line[DEPTH-2:0], new_bit};
    end

    // Polyphase sum: add or subtract the phase's coefficient for each slot.
    always_comb begin
        acc = '0;
        for (int m = 0; m < DEPTH; m++) begin
            int cv;
            cv  = int'(coef_at(NUM_PHASES * m + int'(phase)));
            acc = acc + ACC_W'(line[m] ? -cv : cv);
        end
    end

    // R3
    intake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (line[0] == $past(new_bit)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(line));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(acc) <= BOUND) && (int'(acc) >= -BOUND));

endmodule

// File: rtl/qpsk_iq_mixer.sv
// Module: carrier mixer, registers I*cos - Q*sin at full precision.
// Assumes: all operands are two's-complement signed.
module qpsk_iq_mixer #(
    parameter int ACC_W  = 14,
    parameter int CAR_W  = 10,
    localparam int OUT_W = ACC_W + CAR_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic signed [ACC_W-1:0] acc_q,
    input  logic signed [CAR_W-1:0] cos_s,
    input  logic signed [CAR_W-1:0] sin_s,
    output logic signed [OUT_W-1:0] y
);

    logic signed [OUT_W-1:0] prod_i, prod_q, mix;

    // Widen both operands to the output width, then multiply and subtract.
    always_comb begin
        prod_i = OUT_W'(acc_i) * OUT_W'(cos_s);
        prod_q = OUT_W'(acc_q) * OUT_W'(sin_s);
        mix    = prod_i - prod_q;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            y <= '0;
        else
            y <= mix;
    end

    // R1
    out_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (y == '0));

endmodule

// File: rtl/qpsk_rrc_mod.sv
// Module: QPSK modulator top. It maps symbol bits to two antipodal branches,
// shapes each with a four-phase root-raised-cosine interpolator and mixes
// the result onto the external carrier. Assumes: carrier samples arrive
// every clock, and a symbol offered while ready is low waits.
module qpsk_rrc_mod
    import qpsk_mod_pkg::*;
#(
    parameter int ACC_W  = 14,
    parameter int CAR_W  = 10,
    localparam int OUT_W = ACC_W + CAR_W + 1,
    localparam int PH_W  = $clog2(PHASES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic [1:0]       sym_bits,
    output logic             sym_ready,
    input  logic [CAR_W-1:0] car_cos,
    input  logic [CAR_W-1:0] car_sin,
    output logic [OUT_W-1:0] mod_out
);

    logic [PH_W-1:0]         phase;
    logic                    last_phase;
    logic [1:0]              lane_bit;
    logic signed [ACC_W-1:0] lane_acc [2];
    logic signed [OUT_W-1:0] y;

    qpsk_phase_ctrl #(.NUM_PHASES(PHASES)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .last_phase (last_phase)
    );

    // Lane 1 is in-phase, lane 0 quadrature; idle slots carry +1 (bit 0).
    always_comb lane_bit = sym_valid ? sym_bits : 2'b00;

    for (genvar b = 0; b < 2; b++) begin : g_lane
        qpsk_shaper_branch #(
            .NUM_PHASES (PHASES),
            .DEPTH      (TAPS_PER_PHASE),
            .ACC_W      (ACC_W)
        ) u_branch (
            .clk     (clk),
            .rst_n   (rst_n),
            .shift   (last_phase),
            .new_bit (lane_bit[b]),
            .phase   (phase),
            .acc     (lane_acc[b])
        );
    end

    qpsk_iq_mixer #(.ACC_W(ACC_W), .CAR_W(CAR_W)) u_mix (
        .clk   (clk),
        .rst_n (rst_n),
        .acc_i (lane_acc[1]),
        .acc_q (lane_acc[0]),
        .cos_s ($signed(car_cos)),
        .sin_s ($signed(car_sin)),
        .y     (y)
    );

    always_comb begin
        sym_ready = last_phase;
        mod_out   = y;
    end

endmodule

// File: tb/test_qpsk_rrc_mod.sv
module test_qpsk_rrc_mod;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic [1:0]  sym_bits = 2'b00;
    logic        sym_ready;
    logic [9:0]  car_cos = '0;
    logic [9:0]  car_sin = '0;
    logic [24:0] mod_out;

    int total = 0;
    int bad = 0;

    bit m_i [10];
    bit m_q [10];
    int m_ph = 0;

    always #2 clk = ~clk;

    qpsk_rrc_mod i_qpsk_rrc_mod (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_bits(sym_bits),
        .sym_ready(sym_ready), .car_cos(car_cos), .car_sin(car_sin),
        .mod_out(mod_out)
    );

    // Reference half response (R5), mirrored about tap 18, zero past 36.
    function automatic int ref_h(int k);
        int half [19] = '{-5, -5, -1, 5, 12, 15, 12, 2, -12, -28,
                          -39, -37, -18, 19, 70, 127, 179, 216, 229};
        if (k > 36) return 0;
        if (k > 18) k = 36 - k;
        return half[k];
    endfunction

    function automatic int branch_val(bit q_lane);
        int s = 0;
        for (int m = 0; m < 10; m++) begin
            int c = ref_h(4 * m + m_ph);
            bit neg = q_lane ? m_q[m] : m_i[m];
            s += neg ? -c : c;
        end
        return s;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive, check ready, predict, update model, check output.
    task automatic cyc(bit v, logic [1:0] b, int c, int s, string req);
        int e;
        @(negedge clk);
        sym_valid = v; sym_bits = b;
        car_cos = c[9:0]; car_sin = s[9:0];
        #0.5;
        check("R2", int'(sym_ready), (rst_n && m_ph == 3) ? 1 : 0);
        if (!rst_n) begin
            e = 0;
            for (int k = 0; k < 10; k++) begin m_i[k] = 0; m_q[k] = 0; end
            m_ph = 0;
        end else begin
            e = branch_val(0) * c - branch_val(1) * s;
            if (m_ph == 3) begin
                for (int k = 9; k > 0; k--) begin
                    m_i[k] = m_i[k-1]; m_q[k] = m_q[k-1];
                end
                m_i[0] = v & b[1];
                m_q[0] = v & b[0];
            end
            m_ph = (m_ph + 1) % 4;
        end
        @(posedge clk);
        #1;
        check(req, int'($signed(mod_out)), e);
    endtask

    function automatic int rnd_car();
        return int'($urandom_range(0, 1023)) - 512;
    endfunction

    initial begin
        #(4 * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int k = 0; k < 10; k++) begin m_i[k] = 0; m_q[k] = 0; end
        // R1: reset clears the output while symbols and carriers are offered
        rst_n = 1'b0;
        for (int n = 0; n < 4; n++) cyc(1'b1, 2'b11, 300, -200, "R1");
        rst_n = 1'b1;
        // R4: idle slots feed +1 into both lanes; first ready in cycle 4 (R2)
        for (int n = 0; n < 12; n++) cyc(1'b0, 2'b11, rnd_car(), rnd_car(), "R4");
        // R5: single -1 impulse on the in-phase lane, unit cosine, zero sine
        for (int n = 0; n < 3; n++) cyc(1'b0, 2'b00, 1, 0, "R5");
        cyc(1'b1, 2'b10, 1, 0, "R5");
        for (int n = 0; n < 44; n++) cyc(1'b0, 2'b00, 1, 0, "R5");
        // R3: quadrature impulse seen through the sine carrier
        for (int n = 0; n < 3; n++) cyc(1'b0, 2'b00, 0, -1, "R3");
        cyc(1'b1, 2'b01, 0, -1, "R3");
        for (int n = 0; n < 44; n++) cyc(1'b0, 2'b00, 0, -1, "R3");
        // R8: bits toggle while ready is low; only the ready slot counts
        for (int n = 0; n < 48; n++)
            cyc(1'b1, (n % 4 == 3) ? 2'b00 : 2'(n), rnd_car(), rnd_car(), "R8");
        // R9 and R6: all -1 in both lanes at full-scale carriers
        for (int n = 0; n < 48; n++) cyc(1'b1, 2'b11, -512, 511, "R9");
        for (int n = 0; n < 8; n++) cyc(1'b1, 2'b00, -512, 511, "R6");
        // R7: random symbols, random valid, random carriers
        for (int n = 0; n < 2000; n++)
            cyc(1'($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)),
                rnd_car(), rnd_car(), "R7");
        // R1: mid-stream reset returns histories to +1
        rst_n = 1'b0;
        cyc(1'b1, 2'b11, 77, 55, "R1");
        cyc(1'b1, 2'b11, 77, 55, "R1");
        rst_n = 1'b1;
        for (int n = 0; n < 8; n++) cyc(1'b0, 2'b00, 77, 55, "R1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule